// File: doc/BRIEF.md
# Instruction Cache Line Valid Tracker

This block keeps the bookkeeping for a 512-byte on-chip instruction cache in a small graphics coprocessor. The cache is cut into 32 lines of 16 bytes. The block holds the cache base register, a per-line valid vector and an active flag. It also tells the fetch stage whether a program counter lands inside the cached window. The data RAM and the refill logic live elsewhere. They present every byte write into cache memory to this block as a strobe and a 9-bit cache offset.

A line counts as valid once the byte at the top of that line (offset 15 within the line) has been written. Loading a new base value turns the cache on. A load changes the window only when the aligned value differs from the one already held, and in that case it discards every valid line. A flush or a reset discards everything and turns the cache off. The hit flag is registered. It reflects the state held before the clock edge together with the fetch address presented in that cycle.

Top module: `icache_line_tracker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, line_valid is all zero, base_q is 0, active is 0 and hit is 0.
- R2: A write strobe whose offset has bits [3:0] equal to 4'hF sets bit wr_off[8:4] of line_valid in the next cycle. Bits set earlier stay set.
- R3: A write strobe whose offset bits [3:0] are anything other than 4'hF leaves line_valid unchanged.
- R4: A base load stores base_val with bits [3:0] forced to zero into base_q in the next cycle, and sets active.
- R5: If the aligned load value equals the current base_q, line_valid is kept. If it differs, line_valid is cleared. A write in the same cycle is then applied to the cleared vector.
- R6: A flush clears line_valid, sets base_q to 0 and clears active in the next cycle. It wins over a write strobe or a base load in the same cycle.
- R7: hit, one cycle after fetch_addr is presented, is 1 exactly when active was 1 and the 16-bit difference (fetch_addr - base_q) mod 65536 is below 512. It is 0 whenever the cache is inactive.
- R8: A window that runs past address 16'hFFFF continues from 16'h0000, so fetch addresses just above zero hit when base_q lies within 512 bytes of the top of the space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, same effect as a flush |
| wr_en | input | 1 | A byte is being written into cache memory |
| wr_off | input | 9 | Byte offset of that write inside the cache |
| base_ld | input | 1 | Load the cache base register |
| base_val | input | 16 | Value to load; low 4 bits ignored |
| flush | input | 1 | Invalidate all lines and deactivate the cache |
| fetch_addr | input | 16 | Program counter to test against the window |
| line_valid | output | 32 | One valid bit per cache line |
| base_q | output | 16 | Current line-aligned cache base |
| active | output | 1 | Cache has a loaded base |
| hit | output | 1 | Registered: fetch address was inside the active window |

## Verification
The bench builds the block with its default parameters: 16-bit addresses and 32 lines of 16 bytes. At this size every one of the 512 cache offsets can be written in turn, and every one of the 65536 fetch addresses can be tested against a base that makes the window wrap past the top of the space. A strided sweep against an interior base covers the unwrapped case. Short directed sequences cover equal and differing base reloads, unaligned load values and the same-cycle collisions of flush, load and write.

// File: rtl/icache_track_pkg.sv
package icache_track_pkg;
  localparam int DEF_ADDR_W     = 16;
  localparam int DEF_LINE_BYTES = 16;
  localparam int DEF_NUM_LINES  = 32;

  typedef enum logic [1:0] {
    UPD_HOLD  = 2'd0,
    UPD_CLEAR = 2'd1,
    UPD_RESEL = 2'd2
  } upd_kind_e;
endpackage

// File: rtl/icache_base_reg.sv
module icache_base_reg #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              base_ld,
  input  logic [ADDR_W-1:0] base_val,
  output logic [ADDR_W-1:0] base_q,
  output logic              active,
  output logic              base_moved
);
  logic [ADDR_W-1:0] aligned;

  assign aligned    = {base_val[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign base_moved = base_ld && !flush && (aligned != base_q);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      base_q <= '0;
      active <= 1'b0;
    end else if (base_ld) begin
      base_q <= aligned;
      active <= 1'b1;
    end
  end

  // R4
  base_load_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    (base_ld && !flush) |=> (active && base_q[ADDR_W-1:OFF_W] == $past(base_val[ADDR_W-1:OFF_W])
                              && base_q[OFF_W-1:0] == '0));
endmodule

// File: rtl/icache_valid_vec.sv
module icache_valid_vec
  import icache_track_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int OFF_W     = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic                       base_moved,
  input  logic                       wr_en,
  input  logic [$clog2(NUM_LINES)+OFF_W-1:0] wr_off,
  output logic [NUM_LINES-1:0]       line_valid
);
  localparam int IDX_W = $clog2(NUM_LINES);

  upd_kind_e              kind;
  logic                   last_byte;
  logic [IDX_W-1:0]       idx;

  assign last_byte = wr_en && (wr_off[OFF_W-1:0] == {OFF_W{1'b1}});
  assign idx       = wr_off[IDX_W+OFF_W-1:OFF_W];

  always_comb begin
    if (rst || flush)    kind = UPD_CLEAR;
    else if (base_moved) kind = UPD_RESEL;
    else                 kind = UPD_HOLD;
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic set_me;
    assign set_me = last_byte && (idx == IDX_W'(i));
    always_ff @(posedge clk) begin
      case (kind)
        UPD_CLEAR: line_valid[i] <= 1'b0;
        UPD_RESEL: line_valid[i] <= set_me;
        default:   line_valid[i] <= line_valid[i] | set_me;
      endcase
    end
  end

  // R3
  other_offset_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!flush && !base_moved && !last_byte) |=> $stable(line_valid));

  // R2
  single_line_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!flush && !base_moved && last_byte) |=>
      ($countones(line_valid ^ $past(line_valid)) <= 1 && (line_valid & $past(line_valid)) == $past(line_valid)));
endmodule

// File: rtl/icache_window_cmp.sv
module icache_window_cmp #(
  parameter int ADDR_W      = 16,
  parameter int CACHE_BYTES = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic [ADDR_W-1:0] base_q,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              hit
);
  logic [ADDR_W:0] lo_ext;
  logic [ADDR_W:0] end_ext;
  logic            wraps;
  logic            in_win;

  assign lo_ext  = {1'b0, base_q};
  assign end_ext = lo_ext + (ADDR_W+1)'(CACHE_BYTES);
  assign wraps   = end_ext[ADDR_W];

  always_comb begin
    if (wraps)
      in_win = (fetch_addr >= base_q) || (fetch_addr < end_ext[ADDR_W-1:0]);
    else
      in_win = (fetch_addr >= base_q) && ({1'b0, fetch_addr} < end_ext);
  end

  always_ff @(posedge clk) begin
    if (rst) hit <= 1'b0;
    else     hit <= active && in_win;
  end

  // R7
  hit_needs_active_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(active));
endmodule

// File: rtl/icache_line_tracker.sv
module icache_line_tracker
  import icache_track_pkg::*;
#(
  parameter int ADDR_W     = DEF_ADDR_W,
  parameter int LINE_BYTES = DEF_LINE_BYTES,
  parameter int NUM_LINES  = DEF_NUM_LINES
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [$clog2(LINE_BYTES*NUM_LINES)-1:0] wr_off,
  input  logic                 base_ld,
  input  logic [ADDR_W-1:0]    base_val,
  input  logic                 flush,
  input  logic [ADDR_W-1:0]    fetch_addr,
  output logic [NUM_LINES-1:0] line_valid,
  output logic [ADDR_W-1:0]    base_q,
  output logic                 active,
  output logic                 hit
);
  localparam int OFF_W       = $clog2(LINE_BYTES);
  localparam int CACHE_BYTES = LINE_BYTES * NUM_LINES;

  logic base_moved;

  icache_base_reg #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_base (
    .clk(clk), .rst(rst), .flush(flush), .base_ld(base_ld), .base_val(base_val),
    .base_q(base_q), .active(active), .base_moved(base_moved)
  );

  icache_valid_vec #(.NUM_LINES(NUM_LINES), .OFF_W(OFF_W)) u_valid (
    .clk(clk), .rst(rst), .flush(flush), .base_moved(base_moved),
    .wr_en(wr_en), .wr_off(wr_off), .line_valid(line_valid)
  );

  icache_window_cmp #(.ADDR_W(ADDR_W), .CACHE_BYTES(CACHE_BYTES)) u_win (
    .clk(clk), .rst(rst), .active(active), .base_q(base_q),
    .fetch_addr(fetch_addr), .hit(hit)
  );

  // R6
  flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (line_valid == '0 && base_q == '0 && !active));

  // R5
  same_base_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (base_ld && !flush && !wr_en && base_val[ADDR_W-1:OFF_W] == base_q[ADDR_W-1:OFF_W])
      |=> $stable(line_valid));
endmodule

// File: tb/icache_line_tracker_bench.sv
module icache_line_tracker_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, base_ld, flush;
  logic [8:0]  wr_off;
  logic [15:0] base_val, fetch_addr;
  logic [31:0] line_valid;
  logic [15:0] base_q;
  logic        active, hit;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] m_v;
  logic [15:0] m_b;
  logic        m_a;
  logic        m_h;

  always #2.5 clk = ~clk;

  icache_line_tracker u_icache_line_tracker (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_off(wr_off), .base_ld(base_ld),
    .base_val(base_val), .flush(flush), .fetch_addr(fetch_addr),
    .line_valid(line_valid), .base_q(base_q), .active(active), .hit(hit)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [8:0] off, input logic ld,
                      input logic [15:0] val, input logic fl, input logic [15:0] fa,
                      input string tag);
    logic [15:0] diff;
    logic [15:0] nb;
    @(negedge clk);
    wr_en = wr; wr_off = off; base_ld = ld; base_val = val; flush = fl; fetch_addr = fa;
    diff = fa - m_b;
    m_h = m_a && (diff < 16'd512);
    if (fl) begin
      m_v = '0; m_b = '0; m_a = 1'b0;
    end else begin
      if (ld) begin
        nb = {val[15:4], 4'h0};
        if (nb != m_b) m_v = '0;
        m_b = nb; m_a = 1'b1;
      end
      if (wr && off[3:0] == 4'hF) m_v[off[8:4]] = 1'b1;
    end
    @(posedge clk);
    #1;
    chk({tag, " valid"},  line_valid, m_v);
    chk({tag, " base"},   {16'h0, base_q}, {16'h0, m_b});
    chk({tag, " active"}, {31'h0, active}, {31'h0, m_a});
    chk({tag, " hit"},    {31'h0, hit}, {31'h0, m_h});
  endtask

  initial begin
    #900000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wr_en = 0; wr_off = 0; base_ld = 0; base_val = 0; flush = 0; fetch_addr = 0;
    m_v = '0; m_b = '0; m_a = 0; m_h = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset valid", line_valid, 32'h0);
    chk("R1 reset base", {16'h0, base_q}, 32'h0);
    chk("R1 reset active", {31'h0, active}, 32'h0);
    chk("R1 reset hit", {31'h0, hit}, 32'h0);
    @(negedge clk); rst = 1'b0;
    step(0, 0, 0, 0, 0, 16'h0000, "R1 first cycle");

    // R4: unaligned load, active rises
    step(0, 0, 1, 16'h123B, 0, 16'h0, "R4 load aligned");
    // R2/R3 sweep over all 512 offsets
    for (int o = 0; o < 512; o++)
      step(1, 9'(o), 0, 0, 0, 16'h1230, (o % 16 == 15) ? "R2 last byte" : "R3 other byte");
    // R5 equal reload keeps vector
    step(0, 0, 1, 16'h1234, 0, 16'h0, "R5 same base");
    // R5 differing load with write same cycle
    step(1, 9'h07F, 1, 16'h4000, 0, 16'h0, "R5 new base plus write");
    step(1, 9'h1FF, 0, 0, 0, 16'h0, "R2 top line");
    // R6 flush beats write and load
    step(1, 9'h0AF, 1, 16'h8000, 1, 16'h4000, "R6 flush priority");
    step(0, 0, 0, 0, 0, 16'h0000, "R7 inactive no hit");
    // R7 interior window, strided
    step(0, 0, 1, 16'h7A05, 0, 16'h0, "R4 load interior");
    for (int a = 0; a < 65536; a += 7)
      step(0, 0, 0, 0, 0, 16'(a), "R7 interior sweep");
    // R8 wrapping window, exhaustive
    step(0, 0, 1, 16'hFF3C, 0, 16'h0, "R4 load high");
    for (int a = 0; a < 65536; a++)
      step(0, 0, 0, 0, 0, 16'(a), "R8 wrap sweep");
    step(0, 0, 0, 0, 1, 16'hFF40, "R6 flush");
    step(0, 0, 0, 0, 0, 16'hFF40, "R7 after flush");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule